// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

The block drains one of two transmit queues held in memory as a circular chain of four-word descriptors. A control register block selects the queue and pulses `start`. The walker then begins at that queue's pointer and follows each descriptor's link word. It goes once around the chain and stops when the link leads back to the descriptor it started from.

A descriptor is processed only when bit 31 of its first word is set, which marks it as owned by hardware. Descriptors without that bit are passed over, and the walk continues past them. For each owned descriptor that carries a usable byte count, the walker reads the buffer one 32-bit word at a time and sends the bytes on a byte-wide valid/ready stream, with a last flag on the final byte. An owned descriptor is returned to software whether or not it was sent: the walker rewrites its first word with bit 31 cleared and pulses the cause bit for the queue. The queue pointers belong to the register block, and the walker never changes them.

Descriptor layout, in little-endian 32-bit words at the descriptor address plus 0, 4, 8 and 12:
- Word 0: status word, with the ownership flag in bit 31.
- Word 1: byte count in bits 31:16, and an unused field in bits 15:0.
- Word 2: buffer address, which must be word aligned.
- Word 3: address of the next descriptor.

Top module: `tx_ring_dma`

## Requirements
- R1: While reset is held, `busy`, `tx_tvalid`, `mem_req` and `cause_set` are all low.
- R2: A `start` pulse while idle latches `queue_sel` and begins at `q0_ptr` (queue 0) or `q1_ptr` (queue 1). The walker visits descriptors in link order (word 3) and ends when a link equals the starting pointer. `busy` is high from the cycle after the accepted start until the walk ends. While idle there is no memory request and no stream traffic.
- R3: A descriptor whose word 0 bit 31 is 0 produces no frame, no memory write and no cause pulse.
- R4: An owned descriptor with a byte count (word 1 bits 31:16) from 1 to 2047 is streamed as one frame. The buffer (word 2) is read as whole words. Bytes leave in address order, and the byte at address a is taken from word bits 8*(a mod 4)+7 down to 8*(a mod 4). `tx_tlast` is high on the final byte only. Word 1 bits 15:0 have no effect.
- R5: An owned descriptor whose byte count is 0, or 2048 or more, sends no bytes but is still handed back.
- R6: Handing back a descriptor is a single write of its word 0, with bit 31 cleared and every other bit kept. The walker writes nothing else. A memory request keeps its address, direction and write data until `mem_ack`.
- R7: Each hand-back gives a one-cycle pulse on `cause_set`, in the cycle after the write is acknowledged. The pulse is on bit 3 for queue 0 and on bit 2 for queue 1. Bits 1:0 never pulse.
- R8: A `start` pulse that arrives while `busy` is high has no effect.
- R9: While `tx_tvalid` is high and `tx_tready` is low, `tx_tvalid`, `tx_tdata` and `tx_tlast` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to walk a queue |
| queue_sel | input | 1 | Queue to walk: 0 or 1 |
| q0_ptr | input | 32 | Ring pointer of queue 0 |
| q1_ptr | input | 32 | Ring pointer of queue 1 |
| busy | output | 1 | Walk in progress |
| cause_set | output | 4 | One-cycle cause pulses (bit 3 queue 0, bit 2 queue 1) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_tdata | output | 8 | Frame byte |
| tx_tvalid | output | 1 | Byte valid |
| tx_tready | input | 1 | Sink accepts the byte |
| tx_tlast | output | 1 | Last byte of the frame |

## Verification
The assertions check, on every cycle, the handshake rules: memory requests and stream bytes stay stable until they are taken, and nothing moves while idle. They also check that every write-back has ownership cleared and that each cause pulse is one-hot, lands on a queue bit and follows an acknowledged write. Only the bench scenarios can show the rest: which descriptors are visited and in what order, which ones are skipped, the exact bytes and last-flag positions, the 2047/2048 count boundary, the self-linked single-descriptor ring, the final memory image, and that a second start during a walk changes nothing.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int LANES   = WORD_W / BYTE_W;
  localparam int LANE_W  = $clog2(LANES);
  localparam int OWN_POS = 31;

  typedef enum logic [2:0] {
    W_IDLE,
    W_DESC,
    W_FETCH,
    W_EMIT,
    W_WBACK,
    W_ADV
  } walk_st_t;
endpackage

// File: rtl/txring_rst_sync.sv
module txring_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/txring_unpack.sv
module txring_unpack
  import txring_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              adv,
  input  logic [WORD_W-1:0] word_in,
  output logic [LEN_W-1:0]  cnt,
  output logic [BYTE_W-1:0] byte_out
);
  logic [WORD_W-1:0] word_q;
  logic [LEN_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (load)      word_q <= word_in;
      if (clr | adv) cnt_q  <= cnt_d;
    end
  end

  assign cnt      = cnt_q;
  assign byte_out = word_q[cnt_q[LANE_W-1:0]*BYTE_W +: BYTE_W];
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txring_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LEN_W    = 16,
  parameter int MAX_LEN  = 2048,
  parameter int CAUSE_W  = 4,
  parameter int CAUSE_HI = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              queue_sel,
  input  logic [AW-1:0]     start_ptr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              tready,
  input  logic [LEN_W-1:0]  cnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              emit,
  output logic              last,
  output logic              cnt_clr,
  output logic              word_load,
  output logic              busy,
  output logic [CAUSE_W-1:0] cause_set
);
  walk_st_t st_q, st_d;
  logic [AW-1:0]     cur_q, cur_d, first_q, first_d, buf_q, buf_d, next_q, next_d;
  logic [WORD_W-1:0] cmd_q, cmd_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [1:0]        widx_q, widx_d;
  logic              qs_q, qs_d;
  logic [CAUSE_W-1:0] cause_q, cause_d, cause_map;

  // Map latched queue index to its cause bit: bit CAUSE_HI minus index
  for (genvar g = 0; g < CAUSE_W; g++) begin : g_cause
    if (g <= CAUSE_HI && CAUSE_HI - g < 2) begin : g_hit
      assign cause_map[g] = (qs_q == 1'(CAUSE_HI - g));
    end else begin : g_zero
      assign cause_map[g] = 1'b0;
    end
  end

  assign emit = (st_q == W_EMIT);
  assign last = emit && ((cnt + LEN_W'(1)) == len_q);

  always_comb begin
    st_d = st_q;  cur_d = cur_q;  first_d = first_q;  buf_d = buf_q;
    next_d = next_q;  cmd_d = cmd_q;  len_d = len_q;  widx_d = widx_q;
    qs_d = qs_q;  cause_d = '0;  cnt_clr = 1'b0;  word_load = 1'b0;
    unique case (st_q)
      W_IDLE: if (start) begin
        st_d = W_DESC;  cur_d = start_ptr;  first_d = start_ptr;
        widx_d = '0;  qs_d = queue_sel;
      end
      W_DESC: if (mem_ack) begin
        widx_d = widx_q + 2'd1;
        unique case (widx_q)
          2'd0: cmd_d = mem_rdata;
          2'd1: len_d = mem_rdata[WORD_W-1 -: LEN_W];
          2'd2: buf_d = mem_rdata[AW-1:0];
          default: begin
            next_d  = mem_rdata[AW-1:0];
            cnt_clr = 1'b1;
            if (!cmd_q[OWN_POS])                                  st_d = W_ADV;
            else if (len_q == '0 || len_q >= LEN_W'(MAX_LEN))     st_d = W_WBACK;
            else                                                  st_d = W_FETCH;
          end
        endcase
      end
      W_FETCH: if (mem_ack) begin
        word_load = 1'b1;
        st_d      = W_EMIT;
      end
      W_EMIT: if (tready) begin
        if (last)                    st_d = W_WBACK;
        else if (&cnt[LANE_W-1:0])   st_d = W_FETCH;
      end
      W_WBACK: if (mem_ack) begin
        cause_d = cause_map;
        st_d    = W_ADV;
      end
      W_ADV: begin
        if (next_q == first_q) st_d = W_IDLE;
        else begin
          cur_d  = next_q;
          widx_d = '0;
          st_d   = W_DESC;
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE;  cur_q <= '0;  first_q <= '0;  buf_q <= '0;  next_q <= '0;
      cmd_q <= '0;  len_q <= '0;  widx_q <= '0;  qs_q <= 1'b0;  cause_q <= '0;
    end else begin
      st_q <= st_d;  cur_q <= cur_d;  first_q <= first_d;  buf_q <= buf_d;
      next_q <= next_d;  cmd_q <= cmd_d;  len_q <= len_d;  widx_q <= widx_d;
      qs_q <= qs_d;  cause_q <= cause_d;
    end
  end

  always_comb begin
    unique case (st_q)
      W_DESC:  mem_addr = cur_q + AW'({widx_q, 2'b00});
      W_FETCH: mem_addr = buf_q + AW'({cnt[LEN_W-1:LANE_W], {LANE_W{1'b0}}});
      W_WBACK: mem_addr = cur_q;
      default: mem_addr = '0;
    endcase
  end

  assign mem_req   = (st_q == W_DESC) || (st_q == W_FETCH) || (st_q == W_WBACK);
  assign mem_we    = (st_q == W_WBACK);
  assign mem_wdata = cmd_q & ~(WORD_W'(1) << OWN_POS);
  assign busy      = (st_q != W_IDLE);
  assign cause_set = cause_q;
endmodule

// File: rtl/tx_ring_dma.sv
module tx_ring_dma
  import txring_pkg::*;
#(
  parameter int AW       = 32,
  parameter int LEN_W    = 16,
  parameter int MAX_LEN  = 2048,
  parameter int CAUSE_W  = 4,
  parameter int CAUSE_HI = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               queue_sel,
  input  logic [AW-1:0]      q0_ptr,
  input  logic [AW-1:0]      q1_ptr,
  output logic               busy,
  output logic [CAUSE_W-1:0] cause_set,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic [BYTE_W-1:0]  tx_tdata,
  output logic               tx_tvalid,
  input  logic               tx_tready,
  output logic               tx_tlast
);
  logic             rst_core_n;
  logic [LEN_W-1:0] cnt;
  logic             emit, last, cnt_clr, word_load;
  logic [AW-1:0]    start_ptr;

  assign start_ptr = queue_sel ? q1_ptr : q0_ptr;

  txring_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  txring_walker #(
    .AW(AW), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .CAUSE_W(CAUSE_W), .CAUSE_HI(CAUSE_HI)
  ) u_walk (
    .clk(clk), .rst_n(rst_core_n), .start(start), .queue_sel(queue_sel),
    .start_ptr(start_ptr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tready(tx_tready), .cnt(cnt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .emit(emit), .last(last),
    .cnt_clr(cnt_clr), .word_load(word_load), .busy(busy), .cause_set(cause_set)
  );

  txring_unpack #(.LEN_W(LEN_W)) u_unpack (
    .clk(clk), .rst_n(rst_core_n), .clr(cnt_clr), .load(word_load),
    .adv(emit && tx_tready), .word_in(mem_rdata), .cnt(cnt), .byte_out(tx_tdata)
  );

  assign tx_tvalid = emit;
  assign tx_tlast  = last;
endmodule

// File: rtl/txring_chk.sv
module txring_chk #(
  parameter int AW      = 32,
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic [CAUSE_W-1:0] cause_set,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ack,
  input logic [AW-1:0]      mem_addr,
  input logic [31:0]        mem_wdata,
  input logic               tx_tvalid,
  input logic               tx_tready,
  input logic [7:0]         tx_tdata,
  input logic               tx_tlast
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r1: assert (!busy && !tx_tvalid && !mem_req && cause_set == '0);
    end
  end

  p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_idle_is_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !tx_tvalid);

  p_stream_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid && !tx_tready |=> tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast));

  p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_wback_clears_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  p_cause_queue_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_set) && cause_set[1:0] == 2'b00);

  p_cause_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    |cause_set |-> $past(mem_req && mem_we && mem_ack));
endmodule

bind tx_ring_dma txring_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .start(start), .busy(busy), .cause_set(cause_set),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .tx_tvalid(tx_tvalid), .tx_tready(tx_tready),
  .tx_tdata(tx_tdata), .tx_tlast(tx_tlast)
);

// File: tb/sim_tx_ring_dma.sv
module sim_tx_ring_dma;
  localparam int CLK_P    = 10;
  localparam int WD_LIMIT = 150000;
  localparam int NV       = 8;
  // {queue, start idx[2], own[3], ready mode[2], len0[12], len1[12], len2[12]}
  localparam logic [43:0] VECS [0:NV-1] = '{
    {1'b0, 2'd0, 3'b111, 2'd0, 12'd5,    12'd1,  12'd8},
    {1'b1, 2'd1, 3'b111, 2'd1, 12'd4,    12'd7,  12'd3},
    {1'b0, 2'd2, 3'b101, 2'd0, 12'd6,    12'd9,  12'd2},
    {1'b1, 2'd0, 3'b000, 2'd0, 12'd3,    12'd3,  12'd3},
    {1'b0, 2'd1, 3'b011, 2'd2, 12'h800,  12'd12, 12'd0},
    {1'b1, 2'd2, 3'b110, 2'd2, 12'd0,    12'd0,  12'd13},
    {1'b0, 2'd0, 3'b111, 2'd3, 12'd16,   12'd17, 12'd15},
    {1'b1, 2'd1, 3'b010, 2'd1, 12'd9,    12'd10, 12'd11}
  };

  logic        clk = 1'b0;
  logic        rst_n, start, queue_sel, mem_ack, tx_tready;
  logic [31:0] q0_ptr, q1_ptr, mem_rdata;
  logic        busy, mem_req, mem_we, tx_tvalid, tx_tlast;
  logic [3:0]  cause_set;
  logic [31:0] mem_addr, mem_wdata;
  logic [7:0]  tx_tdata;

  logic [31:0] mem  [0:1023];
  logic [31:0] snap [0:1023];
  logic [31:0] expm [0:1023];
  logic [8:0]  got_b [0:4095];
  logic [8:0]  exp_b [0:4095];
  int got_n, exp_n, exp_cause, c3, c2, clo, cyc, nchk, nfail, rdy_mode;

  always #(CLK_P/2) clk = ~clk;

  tx_ring_dma u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .queue_sel(queue_sel),
    .q0_ptr(q0_ptr), .q1_ptr(q1_ptr), .busy(busy), .cause_set(cause_set),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_tdata(tx_tdata),
    .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tlast(tx_tlast)
  );

  // Memory slave: acknowledges one cycle after a request is seen
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[11:2]];
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  // Ready driver, stream/cause monitor and watchdog, all at the falling edge
  initial begin
    tx_tready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      case (rdy_mode)
        0:       tx_tready = 1'b1;
        1:       tx_tready = cyc[0];
        2:       tx_tready = (cyc % 3) == 0;
        default: tx_tready = ((cyc * 7) % 5) != 0;
      endcase
      if (tx_tvalid && tx_tready) begin
        got_b[got_n] = {tx_tlast, tx_tdata};
        got_n++;
      end
      if (cause_set[3]) c3++;
      if (cause_set[2]) c2++;
      if (cause_set[1:0] != 2'b00) clo++;
      if (cyc > WD_LIMIT) begin
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a ^ (a >> 3) ^ 8'h5A);
  endfunction

  task automatic set_desc(input int addr, input logic own, input logic [15:0] len,
                          input int bufa, input int nxt);
    mem[addr/4]     = {own, 31'(32'h0055_0000 + 32'(addr))};
    mem[addr/4 + 1] = {len, 16'hBEEF};
    mem[addr/4 + 2] = 32'(bufa);
    mem[addr/4 + 3] = 32'(nxt);
  endtask

  // Independent model of one pass around the ring in the memory snapshot
  task automatic predict(input logic [31:0] sp);
    logic [31:0] p, w0, wd;
    logic [15:0] len;
    int idx, a, bufa;
    p = sp;
    exp_n = 0;
    exp_cause = 0;
    for (int j = 0; j < 1024; j++) expm[j] = snap[j];
    for (int it = 0; it < 64; it++) begin
      idx = int'(p[11:2]);
      w0 = snap[idx];
      len = snap[idx + 1][31:16];
      bufa = int'(snap[idx + 2]);
      if (w0[31]) begin
        exp_cause++;
        expm[idx] = w0 & 32'h7FFF_FFFF;
        if (len != 16'd0 && len < 16'd2048) begin
          for (int k = 0; k < int'(len); k++) begin
            a = bufa + k;
            wd = snap[(a / 4) % 1024];
            exp_b[exp_n] = {k == int'(len) - 1, 8'(wd >> (8 * (a % 4)))};
            exp_n++;
          end
        end
      end
      p = snap[idx + 3];
      if (p == sp) break;
    end
  endtask

  task automatic run_walk(input logic qs, input logic [31:0] sp, input bit extra,
                          input string tag);
    int waited, bad_i, bad_w;
    bit injected;
    for (int j = 0; j < 1024; j++) snap[j] = mem[j];
    predict(sp);
    got_n = 0; c3 = 0; c2 = 0; clo = 0;
    if (qs) begin q1_ptr = sp; q0_ptr = 32'h300; end
    else    begin q0_ptr = sp; q1_ptr = 32'h300; end
    @(negedge clk);
    queue_sel = qs;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    injected = 1'b0;
    while (busy && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (extra && !injected && got_n > 0) begin
        start = 1'b1;
        queue_sel = !qs;
        injected = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(waited < 20000, "R2", {tag, " walk ends"}, waited, 20000);
    chk(got_n == exp_n, "R4", {tag, " byte count"}, got_n, exp_n);
    bad_i = -1;
    for (int k = 0; k < exp_n && k < got_n; k++)
      if (bad_i < 0 && got_b[k] !== exp_b[k]) bad_i = k;
    chk(bad_i < 0, "R4", {tag, " bytes and last"},
        bad_i < 0 ? 0 : got_b[bad_i], bad_i < 0 ? 0 : exp_b[bad_i]);
    chk((qs ? c2 : c3) == exp_cause, "R7", {tag, " queue cause pulses"},
        qs ? c2 : c3, exp_cause);
    chk((qs ? c3 : c2) == 0 && clo == 0, "R7", {tag, " other cause bits"},
        (qs ? c3 : c2) + clo, 0);
    bad_w = -1;
    for (int j = 0; j < 1024; j++)
      if (bad_w < 0 && mem[j] !== expm[j]) bad_w = j;
    chk(bad_w < 0, "R6", {tag, " memory image after walk (R3 untouched)"},
        bad_w < 0 ? 0 : mem[bad_w], bad_w < 0 ? 0 : expm[bad_w]);
  endtask

  initial begin
    logic [43:0] v;
    logic [11:0] lens [0:2];
    nchk = 0; nfail = 0; cyc = 0; rdy_mode = 0;
    got_n = 0; c3 = 0; c2 = 0; clo = 0;
    rst_n = 1'b0; start = 1'b0; queue_sel = 1'b0; q0_ptr = '0; q1_ptr = '0;
    for (int j = 0; j < 1024; j++)
      mem[j] = {pat(4*j + 3), pat(4*j + 2), pat(4*j + 1), pat(4*j)};
    set_desc(32'h300, 1'b0, 16'd4, 32'h100, 32'h300);
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    chk(!busy && !tx_tvalid && !mem_req && cause_set == 4'd0, "R1", "outputs in reset",
        {busy, tx_tvalid, mem_req, cause_set}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !mem_req, "R1", "idle after release", {busy, mem_req}, 0);

    // Table of ring configurations, one walk each (R2..R7)
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      lens[0] = v[35:24]; lens[1] = v[23:12]; lens[2] = v[11:0];
      for (int d = 0; d < 3; d++)
        set_desc(32'h20 + 16*d, v[38 + d], 16'(lens[d]), 32'h100 + 32'h80*d,
                 32'h20 + 16*((d + 1) % 3));
      rdy_mode = int'(v[37:36]);
      run_walk(v[43], 32'h20 + 32'(v[42:41]) * 32'h10, 1'b0, $sformatf("vec%0d", i));
    end

    // R8: second start during a walk is ignored
    rdy_mode = 1;
    set_desc(32'h20, 1'b1, 16'd5, 32'h100, 32'h30);
    set_desc(32'h30, 1'b1, 16'd1, 32'h180, 32'h40);
    set_desc(32'h40, 1'b1, 16'd8, 32'h200, 32'h20);
    run_walk(1'b0, 32'h20, 1'b1, "R8 restart ignored");

    // R2, R4: single descriptor linked to itself, one-byte frame
    rdy_mode = 0;
    set_desc(32'h20, 1'b1, 16'd1, 32'h104, 32'h20);
    run_walk(1'b1, 32'h20, 1'b0, "R2 self loop");

    // R5: 2047 sent, 2048 handed back unsent, walk starts on the dropped one
    set_desc(32'h20, 1'b1, 16'd2047, 32'h800, 32'h30);
    set_desc(32'h30, 1'b1, 16'd2048, 32'h100, 32'h20);
    run_walk(1'b0, 32'h30, 1'b0, "R5 count boundary");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule